// File: doc/BRIEF.md
# Oversampled Pixel Decimator and Group Packer

This block sits between an oversampled single-pixel video source and a pipeline that handles several pixels per clock. Each clock it may receive one pixel together with a data-enable and optional line-start and frame-start markers. It keeps one pixel out of every `DECIM` active pixels, counting from the first active pixel of each line. Kept pixels go into a small ring buffer. Skipped pixels never take a slot.

The output side has `LANES` pixel lanes and one shared valid bit. A group is read out only once `LANES` kept pixels of the same line have been stored. Pixels left over at the end of a line, too few to fill a group, are dropped, so no group ever mixes two lines. The decimation factor and the lane count do not have to divide one another. Both sides run on one clock, and the output is never stalled.

Top module: `pxdec_pack`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` and `overflow` are 0, and the buffer is empty.
- R2: A pixel is kept when `in_de` is 1 and either a start marker (`in_sol` or `in_sof`) is high in that cycle, or exactly a multiple of `DECIM` de-high cycles have passed since the last start marker. Cycles with `in_de` low do not advance the count.
- R3: In each output group, lane k (bits `[k*PIX_W +: PIX_W]`) holds the k-th kept pixel of the group in arrival order. Lane 0 holds the earliest one.
- R4: The sequence of groups seen while `out_valid` is 1 is exactly the kept pixels of each line, taken in order and cut into consecutive groups of `LANES`. Every group appears once and only once.
- R5: When the pixel that completes a group is presented in input cycle c, `out_valid` is 1 in cycle c+2 with that group on `out_pix`. In every other cycle `out_valid` is 0.
- R6: A line ends when `in_de` falls. At that point, any kept pixels of the line that do not fill a whole group are discarded and never appear at the output.
- R7: A start marker that arrives while `in_de` was already high in the previous cycle, with no blanking gap, also ends the previous line and discards its partial group. The new line's first pixel is kept.
- R8: Correct grouping holds when `DECIM` and `LANES` share no common factor (default 3 and 2).
- R9: `overflow` is a sticky flag, cleared only by reset. It is set when a kept pixel finds the buffer full. Because the output always drains, it stays 0 for any input stream at the default configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| in_pix | input | PIX_W | Incoming oversampled pixel |
| in_de | input | 1 | Input pixel is active |
| in_sol | input | 1 | First active pixel of a line |
| in_sof | input | 1 | First active pixel of a frame (also starts a line) |
| out_pix | output | LANES*PIX_W | Packed group, lane 0 earliest |
| out_valid | output | 1 | Group on `out_pix` is valid this cycle |
| overflow | output | 1 | Sticky: a kept pixel met a full buffer |

## Verification
The hardest case to reach is a line that ends while a partial group is waiting in the buffer, directly followed by a new line with no blanking gap. In that case the flush and the first write of the new line happen on the same clock edge. The bench sweeps line lengths 1 through 13 against blanking gaps of 0, 1 and 2 cycles, with and without the frame marker. This covers every leftover count and every phase alignment of `DECIM` against `LANES`, including the back-to-back start marker. A bench-side model cuts each line into groups by arithmetic and predicts every cycle's `out_valid` and `out_pix`.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

    // Per-cycle buffer command produced by the phase unit
    typedef struct packed {
        logic keep;   // store this pixel
        logic flush;  // drop the uncommitted partial group first
    } store_cmd_t;

    // Bits needed to hold values 0..n-1, at least one
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pxd_phase.sv
module pxd_phase
    import pxd_pkg::*;
#(
    parameter int DECIM = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       de,
    input  logic       sol,
    input  logic       sof,
    output store_cmd_t cmd
);
    localparam int PH_W = idx_bits(DECIM);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DECIM - 1);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] ph_base;
    logic            de_q;
    logic            start;

    assign start   = sol | sof;
    assign ph_base = start ? '0 : phase;

    always_comb begin
        cmd.keep  = de && (ph_base == '0);
        cmd.flush = de_q && (!de || start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            de_q  <= 1'b0;
        end else begin
            de_q <= de;
            if (de) begin
                phase <= (ph_base == PH_LAST) ? '0 : ph_base + PH_W'(1);
            end
        end
    end
endmodule

// File: rtl/pxd_store.sv
module pxd_store
    import pxd_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int LANES = 2,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  store_cmd_t             cmd,
    input  logic [PIX_W-1:0]       pix,
    output logic                   rd_req,
    output logic [LANES*PIX_W-1:0] rd_group,
    output logic                   overflow
);
    // DEPTH must be a power of two and at least 2*LANES
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int GW = idx_bits(LANES);
    localparam logic [GW-1:0] G_LAST = GW'(LANES - 1);

    logic [PIX_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, cm_ptr, rd_ptr;
    logic [PW-1:0]    wr_base;
    logic [GW-1:0]    gcnt, g_base;
    logic             full;
    logic             do_wr;

    // A line end rolls the write side back to the last whole group
    assign wr_base = cmd.flush ? cm_ptr : wr_ptr;
    assign g_base  = cmd.flush ? '0 : gcnt;
    assign full    = (wr_base - rd_ptr) == PW'(DEPTH);
    assign do_wr   = cmd.keep && !full;
    assign rd_req  = (cm_ptr - rd_ptr) >= PW'(LANES);

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_base[AW-1:0]] <= pix;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            cm_ptr   <= '0;
            rd_ptr   <= '0;
            gcnt     <= '0;
            overflow <= 1'b0;
        end else begin
            wr_ptr <= wr_base + PW'(do_wr);
            if (do_wr) begin
                if (g_base == G_LAST) begin
                    cm_ptr <= wr_base + PW'(1);
                    gcnt   <= '0;
                end else begin
                    gcnt <= g_base + GW'(1);
                end
            end else begin
                gcnt <= g_base;
            end
            if (rd_req) begin
                rd_ptr <= rd_ptr + PW'(LANES);
            end
            if (cmd.keep && full) begin
                overflow <= 1'b1;
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [AW-1:0] ra;
        assign ra = rd_ptr[AW-1:0] + AW'(k);
        assign rd_group[k*PIX_W +: PIX_W] = mem[ra];
    end
endmodule

// File: rtl/pxd_pack.sv
module pxd_pack #(
    parameter int PIX_W = 8,
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_req,
    input  logic [LANES*PIX_W-1:0] rd_group,
    output logic [LANES*PIX_W-1:0] out_pix,
    output logic                   out_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_pix   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= rd_req;
            if (rd_req) begin
                out_pix <= rd_group;
            end
        end
    end
endmodule

// File: rtl/pxdec_pack.sv
module pxdec_pack
    import pxd_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DECIM = 3,
    parameter int LANES = 2,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PIX_W-1:0]       in_pix,
    input  logic                   in_de,
    input  logic                   in_sol,
    input  logic                   in_sof,
    output logic [LANES*PIX_W-1:0] out_pix,
    output logic                   out_valid,
    output logic                   overflow
);
    store_cmd_t             cmd;
    logic                   rd_req;
    logic [LANES*PIX_W-1:0] rd_group;
    logic                   keep_w;

    assign keep_w = cmd.keep;

    pxd_phase #(.DECIM(DECIM)) u_phase (
        .clk (clk),
        .rst (rst),
        .de  (in_de),
        .sol (in_sol),
        .sof (in_sof),
        .cmd (cmd)
    );

    pxd_store #(.PIX_W(PIX_W), .LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .pix      (in_pix),
        .rd_req   (rd_req),
        .rd_group (rd_group),
        .overflow (overflow)
    );

    pxd_pack #(.PIX_W(PIX_W), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .rd_group  (rd_group),
        .out_pix   (out_pix),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/pxdec_pack_chk.sv
module pxdec_pack_chk (
    input logic clk,
    input logic rst,
    input logic in_de,
    input logic in_sol,
    input logic in_sof,
    input logic out_valid,
    input logic overflow,
    input logic keep
);
    AST_RST_IDLE: assert property (@(posedge clk)
        rst |=> (!out_valid && !overflow)); // R1

    AST_START_KEEP: assert property (@(posedge clk) disable iff (rst)
        (in_de && (in_sol || in_sof)) |-> keep); // R2

    AST_VALID_FROM_KEEP: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(keep, 2)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !overflow); // R9
endmodule

bind pxdec_pack pxdec_pack_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_de     (in_de),
    .in_sol    (in_sol),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .overflow  (overflow),
    .keep      (keep_w)
);

// File: tb/test_pxdec_pack.sv
module test_pxdec_pack;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 8;
    localparam int DECIM = 3;
    localparam int LANES = 2;
    localparam int DEPTH = 8;
    localparam int OW = LANES * PIX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PIX_W-1:0] in_pix = '0;
    logic             in_de = 1'b0;
    logic             in_sol = 1'b0;
    logic             in_sof = 1'b0;
    logic [OW-1:0]    out_pix;
    logic             out_valid;
    logic             overflow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // two-stage model of the expected output timing
    logic          s1_v = 1'b0, s2_v = 1'b0;
    logic [OW-1:0] s1_d = '0, s2_d = '0;
    logic [OW-1:0] grp = '0;
    int            kc = 0;
    logic [PIX_W-1:0] val = 8'h01;

    pxdec_pack #(.PIX_W(PIX_W), .DECIM(DECIM), .LANES(LANES), .DEPTH(DEPTH)) i_pxdec_pack (
        .clk(clk), .rst(rst), .in_pix(in_pix), .in_de(in_de), .in_sol(in_sol),
        .in_sof(in_sof), .out_pix(out_pix), .out_valid(out_valid), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            errors = errors + 1;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // check outputs, advance model, drive next input
    task automatic tick(input logic de, input logic sol, input logic sof,
                        input logic [PIX_W-1:0] p, input logic nv, input logic [OW-1:0] nd);
        @(negedge clk);
        checks = checks + 1;
        if (out_valid !== s2_v) begin
            errors = errors + 1;
            $display("FAIL R5 R4 out_valid actual=%0b expected=%0b", out_valid, s2_v);
        end else if (s2_v && out_pix !== s2_d) begin
            errors = errors + 1;
            $display("FAIL R3 R8 out_pix actual=%h expected=%h", out_pix, s2_d);
        end
        checks = checks + 1;
        if (overflow !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R9 overflow actual=%0b expected=0", overflow);
        end
        s2_v = s1_v; s2_d = s1_d;
        s1_v = nv;   s1_d = nd;
        in_de = de; in_sol = sol; in_sof = sof; in_pix = p;
    endtask

    // one line: R2 keep pattern, R6 partial-group discard at line end
    task automatic run_line(input int len, input int gap, input bit use_sof);
        for (int i = 0; i < len; i++) begin
            logic nv;
            logic [OW-1:0] nd;
            nv = 1'b0; nd = '0;
            if (i == 0) kc = 0;           // R6 R7: leftovers of previous line dropped
            if (i % DECIM == 0) begin     // R2
                grp[(kc % LANES)*PIX_W +: PIX_W] = val;
                if (kc % LANES == LANES - 1) begin
                    nv = 1'b1; nd = grp;  // R3 lane order
                end
                kc = kc + 1;
            end
            tick(1'b1, i == 0, use_sof && i == 0, val, nv, nd);
            val = val + 8'h01;
        end
        for (int g = 0; g < gap; g++) begin
            tick(1'b0, 1'b0, 1'b0, 8'hEE, 1'b0, '0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks = checks + 1;
        if (out_valid !== 1'b0 || overflow !== 1'b0) begin
            errors = errors + 1;
            $display("FAIL R1 reset actual=%0b%0b expected=00", out_valid, overflow);
        end
        rst = 1'b0;
        tick(1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
        // sweep: gap 0 exercises R7 back-to-back start markers
        for (int s = 0; s < 2; s++) begin
            for (int gap = 0; gap < 3; gap++) begin
                for (int len = 1; len <= 13; len++) begin
                    run_line(len, gap, s == 1);
                end
            end
        end
        for (int t = 0; t < 6; t++) begin
            tick(1'b0, 1'b0, 1'b0, '0, 1'b0, '0);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule